// File: doc/BRIEF.md
# Satellite Coarse-Acquisition Spreading Code Generator

This block produces the coarse-acquisition spreading code of one selectable satellite, one chip for each clock on which the chip enable is high. Two 10-stage maximal-length feedback shift registers run side by side from a common all-ones start. Their sequences are called G1 and G2. Each sequence repeats every 1023 chips, which is 1 ms at the nominal 1.023 MHz chip rate. A phase selector XORs two stages of G2, and that gives a time-shifted copy of the G2 sequence. Each satellite gets its own shift, chosen through a table of stage pairs. The output chip is the last stage of G1 XORed with this shifted copy.

A preset strobe loads both registers with all ones and clears the chip index. It also captures the satellite selection. A new selection therefore takes effect only at a preset or a reset, and a code that is running is never disturbed. The block also gives a chip index from 0 to 1022 and an epoch pulse that marks the first chip of each period. A correlator or a code tracking loop can use these directly.

The chip stream has no valid/ready handshake. The chip enable is the only pacing control. While it is low, nothing moves, so a consumer applies back-pressure by holding the enable low.

Top module: `gps_ca_gen`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets `chip_idx_o` to 0, loads both registers with all ones and captures `code_sel`. The first chip of every code is therefore 1.
- R2: On each enabled chip, G1 shifts with feedback stage3 XOR stage10 (polynomial 1+x^3+x^10), and G2 shifts with feedback from stages 2,3,6,8,9,10. `chip_o` is G1 stage 10 XOR the two G2 stages selected by the captured code. A `code_sel` value of k selects satellite k+1, and value 0 uses stages 2 and 6.
- R3: After a preset with `code_sel`=0, the first ten chips presented are 1,1,0,0,1,0,0,0,0,0 (octal 1440).
- R4: For every one of the 32 `code_sel` values, the chip sequence repeats exactly after 1023 enabled chips.
- R5: `chip_idx_o` increases by one on every enabled chip and wraps from 1022 to 0.
- R6: `epoch_o` is high exactly when `chip_en` is high and `chip_idx_o` is 0. Index 0 is the state in which both registers hold all ones, so the pulse occurs once per 1023 enabled chips.
- R7: While `chip_en` and `preset` are low, `chip_idx_o`, `chip_o` and the register contents hold.
- R8: A change of `code_sel` without a preset or reset has no effect on `chip_o`.
- R9: A `preset` in the same cycle as `chip_en` wins. The index returns to 0 and the newly selected code restarts from its first chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Advance one chip at this edge |
| preset | input | 1 | Load all ones, clear index, capture selection |
| code_sel | input | SEL_W (5) | Satellite selection, value k = satellite k+1 |
| chip_o | output | 1 | Current code chip |
| epoch_o | output | 1 | First chip of a period, while enabled |
| chip_idx_o | output | IDX_W (10) | Position of the current chip, 0 to 1022 |

## Verification
The preset strobe and a chip advance can arrive on the same edge. The bench provokes this in the middle of a running code: it asserts both together while also changing the selection. It then expects index 0, an epoch and the first chip of the new code, not a shifted old one. A reset that falls together with an enabled chip is driven the same way. A behavioural reference model compares every output on every cycle. In separate stretches, the selection is changed without a preset, and there the reference keeps the old code.

// File: rtl/gca_pkg.sv
package gca_pkg;

  localparam int unsigned STAGES = 10;
  localparam int unsigned CODES  = 32;

  typedef logic [STAGES-1:0] lfsr_state_t;

  // feedback masks: bit i-1 set for stage i of the polynomial
  localparam lfsr_state_t G1_FB = 10'h204;  // stages 3,10
  localparam lfsr_state_t G2_FB = 10'h3A6;  // stages 2,3,6,8,9,10

  typedef struct packed {
    logic [3:0] a;
    logic [3:0] b;
  } tap_pair_t;

  function automatic tap_pair_t tap_lookup(input logic [4:0] code);
    tap_pair_t p;
    case (code)
      5'd0:  p = '{4'd2, 4'd6};
      5'd1:  p = '{4'd3, 4'd7};
      5'd2:  p = '{4'd4, 4'd8};
      5'd3:  p = '{4'd5, 4'd9};
      5'd4:  p = '{4'd1, 4'd9};
      5'd5:  p = '{4'd2, 4'd10};
      5'd6:  p = '{4'd1, 4'd8};
      5'd7:  p = '{4'd2, 4'd9};
      5'd8:  p = '{4'd3, 4'd10};
      5'd9:  p = '{4'd2, 4'd3};
      5'd10: p = '{4'd3, 4'd4};
      5'd11: p = '{4'd5, 4'd6};
      5'd12: p = '{4'd6, 4'd7};
      5'd13: p = '{4'd7, 4'd8};
      5'd14: p = '{4'd8, 4'd9};
      5'd15: p = '{4'd9, 4'd10};
      5'd16: p = '{4'd1, 4'd4};
      5'd17: p = '{4'd2, 4'd5};
      5'd18: p = '{4'd3, 4'd6};
      5'd19: p = '{4'd4, 4'd7};
      5'd20: p = '{4'd5, 4'd8};
      5'd21: p = '{4'd6, 4'd9};
      5'd22: p = '{4'd1, 4'd3};
      5'd23: p = '{4'd4, 4'd6};
      5'd24: p = '{4'd5, 4'd7};
      5'd25: p = '{4'd6, 4'd8};
      5'd26: p = '{4'd7, 4'd9};
      5'd27: p = '{4'd8, 4'd10};
      5'd28: p = '{4'd1, 4'd6};
      5'd29: p = '{4'd2, 4'd7};
      5'd30: p = '{4'd3, 4'd8};
      default: p = '{4'd4, 4'd9};
    endcase
    return p;
  endfunction

  function automatic lfsr_state_t tap_mask(input logic [4:0] code);
    tap_pair_t p;
    p = tap_lookup(code);
    return (lfsr_state_t'(1) << (p.a - 4'd1)) | (lfsr_state_t'(1) << (p.b - 4'd1));
  endfunction

endpackage

// File: rtl/gca_lfsr.sv
module gca_lfsr #(
  parameter int unsigned       LEN     = 10,
  parameter logic [LEN-1:0]    FB_MASK = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_ones,
  input  logic           step,
  output logic [LEN-1:0] state_o
);

  logic [LEN-1:0] st_q;
  logic           fb;

  // bit i-1 holds stage i; new bits enter stage 1
  assign fb = ^(st_q & FB_MASK);

  always_ff @(posedge clk) begin
    if (rst || load_ones) begin
      st_q <= '1;
    end else if (step) begin
      st_q <= {st_q[LEN-2:0], fb};
    end
  end

  assign state_o = st_q;

  // R2
  nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    st_q != '0);

endmodule

// File: rtl/gca_phase_sel.sv
module gca_phase_sel #(
  parameter int unsigned SEL_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       capture,
  input  logic [SEL_W-1:0]           code_sel_i,
  input  gca_pkg::lfsr_state_t       g2_i,
  output logic                       shifted_o
);
  import gca_pkg::*;

  logic [SEL_W-1:0] sel_q;
  lfsr_state_t      mask;

  always_ff @(posedge clk) begin
    if (rst || capture) begin
      sel_q <= code_sel_i;
    end
  end

  assign mask      = tap_mask(5'(sel_q));
  assign shifted_o = ^(g2_i & mask);

  // R2
  two_taps_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mask) == 2);

endmodule

// File: rtl/gca_chip_ctr.sv
module gca_chip_ctr #(
  parameter int unsigned PERIOD = 1023,
  parameter int unsigned IDX_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  output logic [IDX_W-1:0] idx_o,
  output logic             epoch_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(PERIOD - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx_o   = idx_q;
  assign epoch_o = advance && (idx_q == '0);

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !restart && idx_q == LAST) |=> idx_q == '0);

  // R5
  range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST);

endmodule

// File: rtl/gps_ca_gen.sv
module gps_ca_gen #(
  parameter int unsigned SEL_W = 5,
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_en,
  input  logic             preset,
  input  logic [SEL_W-1:0] code_sel,
  output logic             chip_o,
  output logic             epoch_o,
  output logic [IDX_W-1:0] chip_idx_o
);
  import gca_pkg::*;

  localparam int unsigned PERIOD = (1 << STAGES) - 1;

  lfsr_state_t g1_st;
  lfsr_state_t g2_st;
  logic        g2_shift;

  gca_lfsr #(.LEN(STAGES), .FB_MASK(G1_FB)) u_g1 (
    .clk(clk), .rst(rst), .load_ones(preset), .step(chip_en), .state_o(g1_st)
  );

  gca_lfsr #(.LEN(STAGES), .FB_MASK(G2_FB)) u_g2 (
    .clk(clk), .rst(rst), .load_ones(preset), .step(chip_en), .state_o(g2_st)
  );

  gca_phase_sel #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .capture(preset), .code_sel_i(code_sel),
    .g2_i(g2_st), .shifted_o(g2_shift)
  );

  gca_chip_ctr #(.PERIOD(PERIOD), .IDX_W(IDX_W)) u_ctr (
    .clk(clk), .rst(rst), .restart(preset), .advance(chip_en),
    .idx_o(chip_idx_o), .epoch_o(epoch_o)
  );

  assign chip_o = g1_st[STAGES-1] ^ g2_shift;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!chip_en && !preset) |=> ($stable(chip_idx_o) && $stable(chip_o) && $stable(g2_st)));

  // R6
  epoch_align_chk: assert property (@(posedge clk) disable iff (rst)
    epoch_o |-> ((&g1_st) && (&g2_st)));

  // R4
  period_align_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_idx_o == '0) |-> ((&g1_st) && (&g2_st)));

  // R9
  preset_wins_chk: assert property (@(posedge clk) disable iff (rst)
    preset |=> (chip_idx_o == '0 && (&g1_st) && (&g2_st)));

endmodule

// File: tb/gps_ca_gen_bench.sv
module gps_ca_gen_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, chip_en = 1'b0, preset = 1'b0;
  logic [4:0] code_sel = 5'd0;
  logic       chip_o, epoch_o;
  logic [9:0] chip_idx_o;

  gps_ca_gen u_gps_ca_gen (
    .clk(clk), .rst(rst), .chip_en(chip_en), .preset(preset),
    .code_sel(code_sel), .chip_o(chip_o), .epoch_o(epoch_o),
    .chip_idx_o(chip_idx_o)
  );

  int checks = 0, errors = 0, epochs = 0;
  int m1[1:10], m2[1:10];
  int midx = 0, msel = 0;
  string tag = "R1";
  int TA[32] = '{2,3,4,5,1,2,1,2,3,2,3,5,6,7,8,9,1,2,3,4,5,6,1,4,5,6,7,8,1,2,3,4};
  int TB[32] = '{6,7,8,9,9,10,8,9,10,3,4,6,7,8,9,10,4,5,6,7,8,9,3,6,7,8,9,10,6,7,8,9};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(bit en, bit pre, bit r, int sel);
    int f1, f2, echip, eep;
    chip_en = en; preset = pre; rst = r; code_sel = sel[4:0];
    @(posedge clk);
    if (r || pre) begin
      for (int i = 1; i <= 10; i++) begin m1[i] = 1; m2[i] = 1; end
      midx = 0; msel = sel;
    end else if (en) begin
      f1 = m1[3] ^ m1[10];
      f2 = m2[2] ^ m2[3] ^ m2[6] ^ m2[8] ^ m2[9] ^ m2[10];
      for (int i = 10; i > 1; i--) begin m1[i] = m1[i-1]; m2[i] = m2[i-1]; end
      m1[1] = f1; m2[1] = f2;
      midx = (midx + 1) % 1023;
    end
    @(negedge clk);
    echip = m1[10] ^ m2[TA[msel]] ^ m2[TB[msel]];
    eep   = (en && midx == 0) ? 1 : 0;
    if (epoch_o) epochs++;
    checks++;
    if (chip_o !== echip[0] || epoch_o !== eep[0] || chip_idx_o !== midx[9:0]) begin
      errors++;
      $display("FAIL %s chip/epoch/idx: actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, chip_o, epoch_o, chip_idx_o, echip, eep, midx);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first, before_idx, before_chip;
    int q[$];
    @(negedge clk);
    tag = "R1";
    repeat (3) cyc(0, 0, 1, 0);
    chk("R1 reset index", chip_idx_o, 0);
    chk("R1 reset first chip", chip_o, 1);
    chk("R1 reset epoch idle", epoch_o, 0);

    // R3 first ten chips of selection 0
    tag = "R3";
    cyc(0, 1, 0, 0);
    first = 0;
    for (int n = 0; n < 10; n++) begin
      first = first * 2 + chip_o;
      cyc(1, 0, 0, 0);
    end
    chk("R3 first ten chips", first, 'o1440);

    // R4 period of every code, with R2 R5 R6 compared each cycle
    tag = "R2 R4 R5 R6";
    for (int k = 0; k < 32; k++) begin
      cyc(0, 1, 0, k);
      q.delete();
      for (int n = 0; n < 1023; n++) begin
        q.push_back(chip_o);
        cyc(1, 0, 0, k);
      end
      chk("R5 index wrapped", chip_idx_o, 0);
      epochs = 0;
      for (int n = 0; n < 1023; n++) begin
        chk("R4 repeat after 1023", chip_o, q[n]);
        cyc(1, 0, 0, k);
      end
      chk("R6 one epoch per period", epochs, 1);
    end

    // R7 gaps in the enable
    tag = "R7";
    cyc(0, 1, 0, 4);
    for (int n = 0; n < 200; n++) begin
      before_idx  = chip_idx_o;
      before_chip = chip_o;
      cyc((n % 3) != 0, 0, 0, 4);
      if ((n % 3) == 0) begin
        chk("R7 index held", chip_idx_o, before_idx);
        chk("R7 chip held", chip_o, before_chip);
      end
    end

    // R8 selection change without preset
    tag = "R8";
    cyc(0, 1, 0, 2);
    repeat (30) cyc(1, 0, 0, 2);
    for (int n = 0; n < 60; n++) cyc(n % 2, 0, 0, 9 + (n % 5));

    // R9 preset together with an enabled chip mid-period
    tag = "R9";
    repeat (470) cyc(1, 0, 0, 9);
    cyc(1, 1, 0, 17);
    chk("R9 index restarted", chip_idx_o, 0);
    chk("R9 epoch on restart", epoch_o, 1);
    chk("R9 first chip of new code", chip_o, 1);
    repeat (20) cyc(1, 0, 0, 3);

    // R1 reset coinciding with an enabled chip
    tag = "R1";
    cyc(1, 0, 1, 5);
    chk("R1 reset mid-run index", chip_idx_o, 0);
    repeat (40) cyc(1, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule